// File: doc/BRIEF.md
# Receive Ring Page Manager

This block stores received frames in a circular buffer made of 256-byte pages inside a local byte-addressed RAM. Software sets the lowest ring page and the page just past the ring, and keeps a boundary pointer that marks the oldest page it has not yet read. The block owns the current-page pointer, which is where the next frame will be written.

When a frame is offered, the block gets its length and a multicast flag. It works out how many whole pages the frame needs and compares that with the free pages in the ring. If the frame cannot be stored in full, it is dropped without a single write. An accepted frame gets a four-byte header, and its bytes then follow through a valid/ready stream, one RAM write per cycle. The address wraps from the top of the ring back to its base page. At the end the current page moves past the frame and a one-cycle received pulse is raised. Address filtering, host reads of the ring and checksum generation are handled elsewhere.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, busy_o, ram_we_o, pkt_rx_o and s_ready_o are low and curr_o is 0.
- R2: Pages needed = floor((L + 8 + 255) / 256), where L is the stored length. Free pages = bnry - curr when curr < bnry, and (stop - start) - (curr - bnry) otherwise. When fewer pages are free than needed, the frame is dropped: no RAM write, busy_o stays low, curr_o is unchanged, no pulse.
- R3: A frame offered while run_i is low, or while ring_start_i is 0, is dropped in the same way.
- R4: A frame shorter than 40 bytes is dropped unless runt_ok_i is high. An accepted frame shorter than 60 bytes is stored as 60 bytes: the supplied bytes come first, then zero bytes, and the stream is not asked for the padding.
- R5: The four header bytes are written at curr*256+0..3, in the four cycles right after the accepting edge. Byte 0 is 0x01, with bit 5 also set (0x21) for a multicast frame. Byte 1 is the next page. Bytes 2 and 3 are L+4, low byte first.
- R6: Frame bytes follow the header in stream order. A byte is taken only on a cycle with s_valid_i and s_ready_o both high. Each write address is one above the last, except that after the last byte of page stop-1 the next write goes to start*256.
- R7: Next page = curr + pages needed, minus (stop - start) if the sum is at or above stop. In the cycle after the last write, curr_o shows the next page and pkt_rx_o is high for exactly one cycle.
- R8: busy_o is high from the accepting edge until the last byte is written. A frame request made while busy has no effect on the frame in progress.
- R9: While idle, curr_wr_i loads curr_val_i into the current page on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Receiver started; low means stopped |
| runt_ok_i | input | 1 | Accept frames shorter than 40 bytes |
| ring_start_i | input | PAGE_W | First page of the ring |
| ring_stop_i | input | PAGE_W | Page just past the ring |
| bnry_i | input | PAGE_W | Boundary (host read) page |
| curr_wr_i | input | 1 | Load the current page (taken only while idle) |
| curr_val_i | input | PAGE_W | Value for the current-page load |
| curr_o | output | PAGE_W | Current page |
| frm_start_i | input | 1 | Frame offered, one-cycle request |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_mcast_i | input | 1 | Frame is multicast |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte taken this cycle |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | PAGE_W+8 | RAM byte address |
| ram_data_o | output | 8 | RAM write data |
| busy_o | output | 1 | Frame being stored |
| pkt_rx_o | output | 1 | Frame stored, one-cycle pulse |

## Verification
The bench targets the space check at its exact limits. In one case the free pages equal the pages needed and the frame is stored; in the other, one extra byte pushes it onto a second page and it is dropped. A design with an off-by-one in the compare would get one of these two wrong. It also checks a frame that crosses the ring top and one whose next page lands exactly on the stop page. A design that wraps late or to the wrong base would write outside the ring or leave an illegal current page. Runt frames are tried just below and at the 40-byte limit, with padded frames checked for zero fill and for the number of stream bytes taken. A frame request fired in mid-frame checks that a busy block does not restart or change its header.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;
  localparam int MIN_LEN   = 60;
  localparam int RUNT_LEN  = 40;
  localparam int PG_SHIFT  = 8;
  localparam logic [7:0] HDR_OK    = 8'h01;
  localparam logic [7:0] HDR_MCAST = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_BODY = 2'd2
  } ring_st_e;
endpackage

// File: rtl/rx_ring_space.sv
module rx_ring_space
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic [PAGE_W-1:0] ring_start_i,
  input  logic [PAGE_W-1:0] ring_stop_i,
  input  logic [PAGE_W-1:0] bnry_i,
  input  logic [PAGE_W-1:0] curr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              fits_o,
  output logic [PAGE_W-1:0] next_page_o
);
  localparam int SUM_W = LEN_W + 1;
  localparam int CNT_W = SUM_W - PG_SHIFT;
  localparam int CMP_W = ((CNT_W > PAGE_W) ? CNT_W : PAGE_W) + 2;

  logic [SUM_W-1:0] total;
  logic [CNT_W-1:0] pages;
  logic [CMP_W-1:0] need, span, avail, sum, nsum;

  always_comb begin
    total = SUM_W'(len_i) + SUM_W'(HDR_BYTES + CRC_BYTES + 255);
    pages = total[SUM_W-1:PG_SHIFT];
    need  = CMP_W'(pages);
    span  = CMP_W'(ring_stop_i) - CMP_W'(ring_start_i);
    if (curr_i < bnry_i) avail = CMP_W'(bnry_i) - CMP_W'(curr_i);
    else                 avail = span - (CMP_W'(curr_i) - CMP_W'(bnry_i));
    fits_o = (avail >= need);
    sum    = CMP_W'(curr_i) + need;
    nsum   = (sum >= CMP_W'(ring_stop_i)) ? (sum - span) : sum;
    next_page_o = nsum[PAGE_W-1:0];
  end
endmodule

// File: rtl/rx_ring_wptr.sv
module rx_ring_wptr
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  input  logic              step_i,
  input  logic [PAGE_W-1:0] ring_start_i,
  input  logic [PAGE_W-1:0] ring_stop_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PAGE_W-1:0]   page_q;
  logic [PG_SHIFT-1:0] off_q;
  logic [PAGE_W:0]     page_inc;

  assign page_inc = {1'b0, page_q} + 1'b1;
  assign addr_o   = {page_q, off_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= load_page_i;
      off_q  <= '0;
    end else if (step_i) begin
      off_q <= off_q + 1'b1;
      if (&off_q)
        page_q <= (page_inc == {1'b0, ring_stop_i}) ? ring_start_i : page_inc[PAGE_W-1:0];
    end
  end

  // R6: every write stays inside the ring
  a_r6_addr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (page_q >= ring_start_i) && (page_q < ring_stop_i));
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16,
  localparam int ADDR_W = PAGE_W + PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              runt_ok_i,
  input  logic [PAGE_W-1:0] ring_start_i,
  input  logic [PAGE_W-1:0] ring_stop_i,
  input  logic [PAGE_W-1:0] bnry_i,
  input  logic              curr_wr_i,
  input  logic [PAGE_W-1:0] curr_val_i,
  output logic [PAGE_W-1:0] curr_o,
  input  logic              frm_start_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              frm_mcast_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  output logic              s_ready_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_data_o,
  output logic              busy_o,
  output logic              pkt_rx_o
);
  ring_st_e          st_q;
  logic [PAGE_W-1:0] curr_q, next_q, next_d;
  logic [LEN_W-1:0]  len_q, raw_q, cnt_q, eff_len_d, hdr_len;
  logic              mcast_q, pkt_q;
  logic              fits, runt_rej, accept, in_frame, last_byte, idle;

  assign idle      = (st_q == ST_IDLE);
  assign eff_len_d = (frm_len_i < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : frm_len_i;
  assign runt_rej  = (frm_len_i < LEN_W'(RUNT_LEN)) && !runt_ok_i;
  assign accept    = idle && frm_start_i && run_i && (ring_start_i != '0) && !runt_rej && fits;

  rx_ring_space #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_space (
    .ring_start_i (ring_start_i),
    .ring_stop_i  (ring_stop_i),
    .bnry_i       (bnry_i),
    .curr_i       (curr_q),
    .len_i        (eff_len_d),
    .fits_o       (fits),
    .next_page_o  (next_d)
  );

  rx_ring_wptr #(.PAGE_W(PAGE_W)) u_wptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .load_page_i  (curr_q),
    .step_i       (ram_we_o),
    .ring_start_i (ring_start_i),
    .ring_stop_i  (ring_stop_i),
    .addr_o       (ram_addr_o)
  );

  assign hdr_len   = len_q + LEN_W'(HDR_BYTES);
  assign in_frame  = (cnt_q < raw_q);
  assign s_ready_o = (st_q == ST_BODY) && in_frame;
  assign ram_we_o  = (st_q == ST_HDR) || ((st_q == ST_BODY) && (!in_frame || s_valid_i));
  assign last_byte = (st_q == ST_BODY) && ram_we_o && (cnt_q == len_q - LEN_W'(1));

  always_comb begin
    ram_data_o = '0;
    if (st_q == ST_HDR) begin
      case (cnt_q[1:0])
        2'd0:    ram_data_o = HDR_OK | (mcast_q ? HDR_MCAST : 8'h00);
        2'd1:    ram_data_o = 8'(next_q);
        2'd2:    ram_data_o = hdr_len[7:0];
        default: ram_data_o = 8'(hdr_len >> 8);
      endcase
    end else if (in_frame) begin
      ram_data_o = s_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      curr_q  <= '0;
      next_q  <= '0;
      len_q   <= '0;
      raw_q   <= '0;
      cnt_q   <= '0;
      mcast_q <= 1'b0;
      pkt_q   <= 1'b0;
    end else begin
      pkt_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_HDR;
            cnt_q   <= '0;
            len_q   <= eff_len_d;
            raw_q   <= frm_len_i;
            mcast_q <= frm_mcast_i;
            next_q  <= next_d;
          end else if (curr_wr_i) begin
            curr_q <= curr_val_i;
          end
        end
        ST_HDR: begin
          if (cnt_q == LEN_W'(HDR_BYTES - 1)) begin
            st_q  <= ST_BODY;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_BODY: begin
          if (ram_we_o) cnt_q <= cnt_q + 1'b1;
          if (last_byte) begin
            st_q   <= ST_IDLE;
            curr_q <= next_q;
            pkt_q  <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign curr_o   = curr_q;
  assign busy_o   = !idle;
  assign pkt_rx_o = pkt_q;

  a_r8_write_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_o);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rx_o |=> !pkt_rx_o);
  a_r7_curr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(curr_o) |-> pkt_rx_o || $past(curr_wr_i && !busy_o));
  a_r6_ready_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> busy_o);
  a_r5_hdr_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ram_we_o);
  a_r2_no_room_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_start_i && !busy_o && !fits) |=> !busy_o);
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
  typedef struct packed {
    logic       run;
    logic       runt;
    logic       mc;
    logic [7:0] ps;
    logic [7:0] pe;
    logic [7:0] bn;
    logic [7:0] cu;
    logic [15:0] len;
    logic       acc;
    logic [7:0] nxt;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h40,8'h40,16'd60 ,1'b1,8'h41}, // R5 basic
    '{1'b1,1'b0,1'b1,8'h40,8'h48,8'h40,8'h41,16'd100,1'b1,8'h42}, // R5 mcast, R8 poke
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h44,8'h47,16'd300,1'b1,8'h41}, // R6 wrap
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h44,8'h47,16'd60 ,1'b1,8'h40}, // R7 lands on stop
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h43,8'h42,16'd248,1'b1,8'h43}, // R2 exact fit
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h43,8'h42,16'd249,1'b0,8'h42}, // R2 one short
    '{1'b0,1'b0,1'b0,8'h40,8'h48,8'h40,8'h40,16'd60 ,1'b0,8'h40}, // R3 stopped
    '{1'b1,1'b0,1'b0,8'h00,8'h08,8'h00,8'h01,16'd60 ,1'b0,8'h01}, // R3 start 0
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h40,8'h45,16'd39 ,1'b0,8'h45}, // R4 runt
    '{1'b1,1'b1,1'b0,8'h40,8'h48,8'h40,8'h45,16'd39 ,1'b1,8'h46}, // R4 runt ok
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h40,8'h46,16'd40 ,1'b1,8'h47}, // R4 at limit
    '{1'b1,1'b0,1'b0,8'h40,8'h48,8'h46,8'h45,16'd400,1'b0,8'h45}, // R2 curr<bnry
    '{1'b1,1'b0,1'b0,8'h40,8'h50,8'h41,8'h4E,16'd600,1'b1,8'h41}  // R7 multi-page
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic run_i = 1'b0, runt_ok_i = 1'b0, curr_wr_i = 1'b0, frm_start_i = 1'b0;
  logic frm_mcast_i = 1'b0, s_valid_i = 1'b0;
  logic [7:0] ring_start_i = '0, ring_stop_i = '0, bnry_i = '0, curr_val_i = '0, s_data_i = '0;
  logic [15:0] frm_len_i = '0;
  logic [7:0] curr_o, ram_data_o;
  logic [15:0] ram_addr_o;
  logic s_ready_o, ram_we_o, busy_o, pkt_rx_o;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  rx_ring_mgr uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .runt_ok_i(runt_ok_i),
    .ring_start_i(ring_start_i), .ring_stop_i(ring_stop_i), .bnry_i(bnry_i),
    .curr_wr_i(curr_wr_i), .curr_val_i(curr_val_i), .curr_o(curr_o),
    .frm_start_i(frm_start_i), .frm_len_i(frm_len_i), .frm_mcast_i(frm_mcast_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o),
    .busy_o(busy_o), .pkt_rx_o(pkt_rx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'(j * 7 + seed * 13 + 3);
  endfunction

  task automatic run_vec(input int id, input vec_t v, input bit poke);
    int eff, raw, widx, bidx, npulse, nwr, ncyc;
    logic [15:0] ea;
    logic [7:0] ed, pg;
    bit took, poked;
    raw = int'(v.len);
    eff = (raw < 60) ? 60 : raw;
    @(negedge clk);
    run_i = v.run; runt_ok_i = v.runt; ring_start_i = v.ps; ring_stop_i = v.pe; bnry_i = v.bn;
    curr_wr_i = 1'b1; curr_val_i = v.cu;
    @(negedge clk);
    curr_wr_i = 1'b0;
    chk($sformatf("R9 curr load v%0d", id), 32'(curr_o), 32'(v.cu));
    frm_start_i = 1'b1; frm_len_i = v.len; frm_mcast_i = v.mc;
    s_valid_i = 1'b1; bidx = 0; s_data_i = pat(id, 0);
    @(negedge clk);
    frm_start_i = 1'b0;
    widx = 0; npulse = 0; nwr = 0; poked = 1'b0;
    ea = {v.cu, 8'h00};
    ncyc = v.acc ? (eff + 8) : 8;
    for (int c = 0; c < ncyc; c++) begin
      took = s_ready_o && s_valid_i;
      if (ram_we_o) begin
        nwr++;
        case (widx)
          0: ed = 8'h01 | (v.mc ? 8'h20 : 8'h00);
          1: ed = v.nxt;
          2: ed = 8'(eff + 4);
          3: ed = 8'((eff + 4) >> 8);
          default: ed = ((widx - 4) < raw) ? pat(id, widx - 4) : 8'h00;
        endcase
        if (v.acc) begin
          chk($sformatf("R6 addr v%0d w%0d", id, widx), 32'(ram_addr_o), 32'(ea));
          chk($sformatf("%s data v%0d w%0d", (widx < 4) ? "R5" : "R4/R6", id, widx),
              32'(ram_data_o), 32'(ed));
        end
        widx++;
        if (ea[7:0] == 8'hff) begin
          pg = ea[15:8] + 8'd1;
          if (pg == v.pe) pg = v.ps;
          ea = {pg, 8'h00};
        end else begin
          ea = ea + 16'd1;
        end
      end
      if (pkt_rx_o) begin
        npulse++;
        chk($sformatf("R7 next page v%0d", id), 32'(curr_o), 32'(v.nxt));
        chk($sformatf("R8 idle at pulse v%0d", id), 32'(busy_o), 32'd0);
      end
      if (poke && !poked && widx == 2) begin
        frm_start_i = 1'b1; frm_len_i = 16'd70; frm_mcast_i = 1'b0;
        poked = 1'b1;
      end
      @(posedge clk);
      frm_start_i = 1'b0;
      if (took) begin
        bidx++;
        s_data_i = pat(id, bidx);
      end
      @(negedge clk);
    end
    s_valid_i = 1'b0;
    if (v.acc) begin
      chk($sformatf("R7 pulse count v%0d", id), 32'(npulse), 32'd1);
      chk($sformatf("R6 write count v%0d", id), 32'(nwr), 32'(eff + 4));
      chk($sformatf("R4 stream bytes taken v%0d", id), 32'(bidx), 32'(raw));
    end else begin
      chk($sformatf("R2/R3/R4 drop no write v%0d", id), 32'(nwr), 32'd0);
      chk($sformatf("R2/R3/R4 drop no pulse v%0d", id), 32'(npulse), 32'd0);
      chk($sformatf("R2/R3/R4 drop curr kept v%0d", id), 32'(curr_o), 32'(v.cu));
    end
    chk($sformatf("R8 busy ends v%0d", id), 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 we", 32'(ram_we_o), 32'd0);
    chk("R1 pulse", 32'(pkt_rx_o), 32'd0);
    chk("R1 ready", 32'(s_ready_o), 32'd0);
    chk("R1 curr", 32'(curr_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 curr after release", 32'(curr_o), 32'd0);
    for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i], i == 1);
    // R9: the current page loaded while idle is the base of the next frame
    run_vec(20, '{1'b1,1'b0,1'b1,8'h10,8'h14,8'h10,8'h13,16'd64,1'b1,8'h10}, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule